// File: doc/BRIEF.md
# CPU Stop-Clock Power Controller

This block decides when the processor is asked to stop its clock. It drives an active-low stop request and an enable for the processor's external clock. It runs one automatic sequence and two software-started ones.

In throttling, the request is asserted for a programmable number of ticks and then released for another programmable number of ticks. The cycle repeats for as long as the enable bit stays set. A break event ends an asserted phase early. A system event lengthens a released phase by reloading its timer.

Software starts a sleep sequence by reading the power-management command port, which arrives here as a one-cycle strobe. A 2-bit mode field chooses the sequence:
- Stop-grant holds the request until a break event.
- Clock-stop also turns the clock enable off. When a break event ends it, the block restarts the clock and waits a fixed settling time before it releases the request.

Top module: `stpc_ctrl`

## Requirements
- R1: After synchronous active-low reset, `stop_req_n` is 1, `cpu_clk_en` is 1 and `state_o` is 0. The state codes are: 0 idle, 1 throttle asserted, 2 throttle released, 3 stop-grant, 4 clock-stop entry, 5 clock gated, 6 clock settling.
- R2: While `thr_en` is 1 and `tick` is held high, throttling starts from idle in the asserted phase. That phase lasts `lo_reload`+1 cycles. The released phase that follows lasts `hi_reload`+1 cycles, and the pair repeats. A timer moves only on cycles where `tick` is 1.
- R3: A break event during the asserted throttle phase releases the request on the next cycle and starts a full released phase.
- R4: A system event during the released phase reloads the high timer. The phase then ends `hi_reload`+1 cycles after the cycle that followed the event.
- R5: Clearing `thr_en` during either throttle phase moves the block to idle, with the request released, on the next clock.
- R6: A command strobe with `sw_mode` = 01 asserts the request on the next cycle (state 3). The request stays asserted until a break event and is released on the cycle after it.
- R7: A command strobe with `sw_mode` = 10 asserts the request on the next cycle (state 4). On the cycle after that, `cpu_clk_en` goes to 0 (state 5). Both hold until a break event, and further strobes are ignored.
- R8: A break event in the gated state sets `cpu_clk_en` to 1 on the next cycle while the request stays asserted. The request is released after a further settle window of `CLK_HZ`/1e6 × `SETTLE_US` cycles.
- R9: A command strobe with `sw_mode` = 00 or 11 is ignored. Break and system events in idle have no effect.
- R10: A software sequence overrides throttling. When it exits, the block resumes in the released throttle phase if `thr_en` is 1, and goes to idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_en | input | 1 | Throttle enable |
| sw_mode | input | 2 | Software sequence select |
| lo_reload | input | LOAD_W | Asserted-phase length in ticks |
| hi_reload | input | LOAD_W | Released-phase length in ticks |
| tick | input | 1 | Timer time base |
| cmd_rd | input | 1 | One-cycle command-port read strobe |
| brk_evt | input | 1 | Break event pulse |
| sys_evt | input | 1 | System event pulse |
| stop_req_n | output | 1 | Active-low stop-clock request |
| cpu_clk_en | output | 1 | Processor clock enable |
| state_o | output | 3 | Current sequence state |

## Verification
A wrong state shows at the ports on the next cycle, because both outputs and `state_o` are decoded directly from the state register.

A wrong timer load or decrement does not show at once. It appears as an asserted or released phase that is off by one or more cycles, and it is caught at the first phase boundary. The sweep over all small reload pairs times two full periods, so it catches a boundary that is off in either direction.

An error in the settling exit would show as a request released while the clock enable is still low, or one settle window too early or too late.

// File: rtl/stpc_pkg.sv
// Shared types for the stop-clock controller.
package stpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_THR_ON    = 3'd1,
        ST_THR_OFF   = 3'd2,
        ST_GRANT     = 3'd3,
        ST_GATE_PREP = 3'd4,
        ST_GATED     = 3'd5,
        ST_SETTLE    = 3'd6
    } stpc_state_e;

    localparam logic [1:0] MODE_GRANT   = 2'b01;
    localparam logic [1:0] MODE_CLKSTOP = 2'b10;
endpackage

// File: rtl/stpc_timer.sv
// Down-counting phase timer.
// Load copies the reload value. Otherwise the count drops by one on each
// tick until it reaches zero. Assumes load and tick are synchronous to clk.
module stpc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload,
    input  logic         tick,
    output logic         expired
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= reload;
        else if (tick && cnt != '0)
            cnt <= cnt - ONE;
    end

    assign expired = (cnt == '0);

    // R2: without a load the count never rises.
    p_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt));

    // R2: without a tick the count holds.
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/stpc_settle.sv
// Clock settling delay.
// Start arms a window of CYC cycles, and done is high from the last cycle
// of that window on. Assumes CYC >= 1.
module stpc_settle #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    // Arm on start, then count every cycle down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= LAST;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign done = (cnt == '0);

    // R8: an armed window never jumps upward except on start.
    p_settle_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> cnt <= $past(cnt));
endmodule

// File: rtl/stpc_fsm.sv
// Sequence controller.
// It chooses between throttling and the two software sleep sequences,
// issues timer loads and decodes the outputs from the state register.
// Assumes the command, break and system events are single-cycle pulses.
module stpc_fsm
    import stpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        thr_en,
    input  logic [1:0]  sw_mode,
    input  logic        cmd_rd,
    input  logic        brk_evt,
    input  logic        sys_evt,
    input  logic        lo_exp,
    input  logic        hi_exp,
    input  logic        settle_done,
    output logic        lo_load,
    output logic        hi_load,
    output logic        settle_start,
    output logic        stop_req_n,
    output logic        cpu_clk_en,
    output stpc_state_e state
);
    stpc_state_e nxt;
    logic        go_grant;
    logic        go_stop;

    assign go_grant = cmd_rd && (sw_mode == MODE_GRANT);
    assign go_stop  = cmd_rd && (sw_mode == MODE_CLKSTOP);

    // Next-state and timer-load decision.
    always_comb begin
        nxt          = state;
        lo_load      = 1'b0;
        hi_load      = 1'b0;
        settle_start = 1'b0;
        case (state)
            ST_IDLE: begin
                if (go_grant)      nxt = ST_GRANT;
                else if (go_stop)  nxt = ST_GATE_PREP;
                else if (thr_en) begin
                    nxt     = ST_THR_ON;
                    lo_load = 1'b1;
                end
            end
            ST_THR_ON: begin
                if (go_grant)      nxt = ST_GRANT;
                else if (go_stop)  nxt = ST_GATE_PREP;
                else if (!thr_en)  nxt = ST_IDLE;
                else if (brk_evt || lo_exp) begin
                    nxt     = ST_THR_OFF;
                    hi_load = 1'b1;
                end
            end
            ST_THR_OFF: begin
                if (go_grant)      nxt = ST_GRANT;
                else if (go_stop)  nxt = ST_GATE_PREP;
                else if (!thr_en)  nxt = ST_IDLE;
                else if (sys_evt)  hi_load = 1'b1;
                else if (hi_exp) begin
                    nxt     = ST_THR_ON;
                    lo_load = 1'b1;
                end
            end
            ST_GRANT: begin
                if (brk_evt) begin
                    if (thr_en) begin
                        nxt     = ST_THR_OFF;
                        hi_load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_GATE_PREP: nxt = ST_GATED;
            ST_GATED: begin
                if (brk_evt) begin
                    nxt          = ST_SETTLE;
                    settle_start = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    if (thr_en) begin
                        nxt     = ST_THR_OFF;
                        hi_load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output decode from the state register.
    always_comb begin
        stop_req_n = (state == ST_IDLE) || (state == ST_THR_OFF);
        cpu_clk_en = (state != ST_GATED);
    end

    // R7: the clock is only gated while the request is asserted.
    p_gate_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> !stop_req_n);

    // R8: leaving the gated state restarts the clock and keeps the request.
    p_clk_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATED && brk_evt) |=> (cpu_clk_en && !stop_req_n));

    // R6: a break event ends stop-grant.
    p_grant_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GRANT && brk_evt) |=> stop_req_n);

    // R3: a break event ends the asserted throttle phase at once.
    p_brk_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THR_ON && thr_en && brk_evt && !cmd_rd) |=> stop_req_n);

    // R5: dropping the enable leaves throttling on the next clock.
    p_thr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_THR_ON || state == ST_THR_OFF) && !thr_en && !cmd_rd)
        |=> state == ST_IDLE);

    // R9: reserved or disabled modes leave idle untouched.
    p_mode_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !thr_en && !go_grant && !go_stop)
        |=> state == ST_IDLE);
endmodule

// File: rtl/stpc_ctrl.sv
// Top of the stop-clock controller.
// It ties two phase timers and the settle delay to the sequence FSM.
// Timer reloads are in tick units. The settle window is
// (CLK_HZ / 1e6) * SETTLE_US cycles, which must be at least one.
module stpc_ctrl
    import stpc_pkg::*;
#(
    parameter int LOAD_W    = 8,
    parameter int CLK_HZ    = 250_000_000,
    parameter int SETTLE_US = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_en,
    input  logic [1:0]        sw_mode,
    input  logic [LOAD_W-1:0] lo_reload,
    input  logic [LOAD_W-1:0] hi_reload,
    input  logic              tick,
    input  logic              cmd_rd,
    input  logic              brk_evt,
    input  logic              sys_evt,
    output logic              stop_req_n,
    output logic              cpu_clk_en,
    output logic [2:0]        state_o
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

    logic        lo_load, hi_load, settle_start;
    logic        lo_exp, hi_exp, settle_done;
    stpc_state_e state;

    stpc_timer #(.W(LOAD_W)) u_lo_tmr (
        .clk(clk), .rst_n(rst_n), .load(lo_load), .reload(lo_reload),
        .tick(tick), .expired(lo_exp)
    );

    stpc_timer #(.W(LOAD_W)) u_hi_tmr (
        .clk(clk), .rst_n(rst_n), .load(hi_load), .reload(hi_reload),
        .tick(tick), .expired(hi_exp)
    );

    stpc_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(settle_start), .done(settle_done)
    );

    stpc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .sw_mode(sw_mode),
        .cmd_rd(cmd_rd), .brk_evt(brk_evt), .sys_evt(sys_evt),
        .lo_exp(lo_exp), .hi_exp(hi_exp), .settle_done(settle_done),
        .lo_load(lo_load), .hi_load(hi_load), .settle_start(settle_start),
        .stop_req_n(stop_req_n), .cpu_clk_en(cpu_clk_en), .state(state)
    );

    assign state_o = state;
endmodule

// File: tb/stpc_ctrl_tb.sv
`timescale 1ns/1ps
module stpc_ctrl_tb;
    localparam int LW = 4;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          thr_en = 1'b0;
    logic [1:0]    sw_mode = 2'b00;
    logic [LW-1:0] lo_reload = '0;
    logic [LW-1:0] hi_reload = '0;
    logic          tick = 1'b1;
    logic          cmd_rd = 1'b0;
    logic          brk_evt = 1'b0;
    logic          sys_evt = 1'b0;
    logic          stop_req_n, cpu_clk_en;
    logic [2:0]    state_o;

    int  n_vec = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    stpc_ctrl #(.LOAD_W(LW), .CLK_HZ(16_000_000), .SETTLE_US(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .sw_mode(sw_mode),
        .lo_reload(lo_reload), .hi_reload(hi_reload), .tick(tick),
        .cmd_rd(cmd_rd), .brk_evt(brk_evt), .sys_evt(sys_evt),
        .stop_req_n(stop_req_n), .cpu_clk_en(cpu_clk_en), .state_o(state_o)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic e_req, input logic e_en,
                       input logic [2:0] e_st);
        n_vec++;
        if (stop_req_n !== e_req || cpu_clk_en !== e_en || state_o !== e_st) begin
            n_fail++;
            $display("FAIL %s: req_n=%0b en=%0b st=%0d expected req_n=%0b en=%0b st=%0d",
                     rq, stop_req_n, cpu_clk_en, state_o, e_req, e_en, e_st);
        end
    endtask

    task automatic pulse_brk();
        brk_evt = 1'b1; cyc(); brk_evt = 1'b0;
    endtask

    task automatic pulse_cmd(input logic [1:0] m);
        sw_mode = m; cmd_rd = 1'b1; cyc(); cmd_rd = 1'b0;
    endtask

    task automatic to_idle();
        thr_en = 1'b0; cyc(); cyc();
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        chk("R1", 1'b1, 1'b1, 3'd0);
        rst_n = 1'b1;
        cyc();
        chk("R1", 1'b1, 1'b1, 3'd0);

        // R2: sweep all small reload pairs over two full periods
        for (int lo = 0; lo < 4; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
                to_idle();
                lo_reload = LW'(lo); hi_reload = LW'(hi);
                thr_en = 1'b1;
                for (int c = 0; c < 2 * (lo + hi + 2); c++) begin
                    cyc();
                    if ((c % (lo + hi + 2)) <= lo) chk("R2", 1'b0, 1'b1, 3'd1);
                    else                          chk("R2", 1'b1, 1'b1, 3'd2);
                end
            end
        end

        // R2: timers freeze while tick is low
        to_idle();
        lo_reload = 4'd2; hi_reload = 4'd1; thr_en = 1'b1;
        cyc(); chk("R2", 1'b0, 1'b1, 3'd1);
        tick = 1'b0;
        for (int i = 0; i < 5; i++) begin cyc(); chk("R2", 1'b0, 1'b1, 3'd1); end
        tick = 1'b1;
        cyc(); chk("R2", 1'b0, 1'b1, 3'd1);
        cyc(); chk("R2", 1'b0, 1'b1, 3'd1);
        cyc(); chk("R2", 1'b1, 1'b1, 3'd2);

        // R3: break cuts the asserted phase
        to_idle();
        lo_reload = 4'd5; hi_reload = 4'd2; thr_en = 1'b1;
        cyc(); cyc();
        pulse_brk(); chk("R3", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R3", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R3", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R3", 1'b0, 1'b1, 3'd1);

        // R4: system event stretches the released phase
        to_idle();
        lo_reload = 4'd1; hi_reload = 4'd3; thr_en = 1'b1;
        cyc(); cyc(); cyc();
        chk("R4", 1'b1, 1'b1, 3'd2);
        cyc(); cyc();
        sys_evt = 1'b1; cyc(); sys_evt = 1'b0;
        for (int c = 3; c < 7; c++) chk_and_step: begin
            chk("R4", 1'b1, 1'b1, 3'd2); cyc();
        end
        chk("R4", 1'b0, 1'b1, 3'd1);

        // R5: dropping enable in each phase
        to_idle();
        lo_reload = 4'd5; hi_reload = 4'd5; thr_en = 1'b1;
        cyc(); cyc();
        thr_en = 1'b0; cyc(); chk("R5", 1'b1, 1'b1, 3'd0);
        thr_en = 1'b1;
        for (int i = 0; i < 7; i++) cyc();
        chk("R5", 1'b1, 1'b1, 3'd2);
        thr_en = 1'b0; cyc(); chk("R5", 1'b1, 1'b1, 3'd0);

        // R6: stop-grant from idle
        cyc();
        pulse_cmd(2'b01); chk("R6", 1'b0, 1'b1, 3'd3);
        sys_evt = 1'b1;
        for (int i = 0; i < 8; i++) begin cyc(); chk("R6", 1'b0, 1'b1, 3'd3); end
        sys_evt = 1'b0;
        pulse_brk(); chk("R6", 1'b1, 1'b1, 3'd0);

        // R10: stop-grant overrides throttling, then resumes released
        lo_reload = 4'd1; hi_reload = 4'd2; thr_en = 1'b1;
        cyc(); chk("R10", 1'b0, 1'b1, 3'd1);
        pulse_cmd(2'b01); chk("R10", 1'b0, 1'b1, 3'd3);
        for (int i = 0; i < 3; i++) begin cyc(); chk("R10", 1'b0, 1'b1, 3'd3); end
        pulse_brk(); chk("R10", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R10", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R10", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R10", 1'b0, 1'b1, 3'd1);

        // R7: clock-stop entry and hold
        to_idle();
        pulse_cmd(2'b10); chk("R7", 1'b0, 1'b1, 3'd4);
        cyc(); chk("R7", 1'b0, 1'b0, 3'd5);
        pulse_cmd(2'b01); chk("R7", 1'b0, 1'b0, 3'd5);
        for (int i = 0; i < 6; i++) begin cyc(); chk("R7", 1'b0, 1'b0, 3'd5); end

        // R8: exit restarts clock, then settles
        pulse_brk(); chk("R8", 1'b0, 1'b1, 3'd6);
        for (int c = 1; c < SETTLE; c++) begin cyc(); chk("R8", 1'b0, 1'b1, 3'd6); end
        cyc(); chk("R8", 1'b1, 1'b1, 3'd0);

        // R10: clock-stop exit resumes throttling in released phase
        pulse_cmd(2'b10); cyc();
        chk("R10", 1'b0, 1'b0, 3'd5);
        thr_en = 1'b1; lo_reload = 4'd1; hi_reload = 4'd1;
        pulse_brk();
        for (int c = 1; c < SETTLE; c++) cyc();
        chk("R10", 1'b0, 1'b1, 3'd6);
        cyc(); chk("R10", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R10", 1'b1, 1'b1, 3'd2);
        cyc(); chk("R10", 1'b0, 1'b1, 3'd1);

        // R9: disabled and reserved modes, stray events in idle
        to_idle();
        pulse_cmd(2'b00); chk("R9", 1'b1, 1'b1, 3'd0);
        pulse_cmd(2'b11); chk("R9", 1'b1, 1'b1, 3'd0);
        pulse_brk(); chk("R9", 1'b1, 1'b1, 3'd0);
        sys_evt = 1'b1; cyc(); sys_evt = 1'b0; chk("R9", 1'b1, 1'b1, 3'd0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule